// File: doc/BRIEF.md
# Chained Command Packet Walker

This block follows a chain of command packets held in a 2 MB system memory and streams each packet's payload words to a downstream command framer. Every packet (node) begins with one header word. The header's top byte gives the number of payload words that follow it, and its low 24 bits give the address of the next node. A pulse on the start input begins the walk at a 32-bit address. Only the low 24 bits of that address are used, and a 24-bit address selects a memory word through its byte-address bits 20:2.

The walk finishes normally when an address with bit 23 set is reached. It aborts when the next address matches a reference address used to catch loops, or when too many nodes have been visited. The reference is first the start address. It is reloaded with the current next address each time the count of visited nodes reaches a threshold, and that threshold doubles at each reload. A running cost figure is kept for the walk. At completion, a one-cycle done pulse is raised, and the outcome code and the last address reached are held on the outputs.

The memory port returns read data one cycle after a request. Payload words leave through a valid/ready pair in address order. The walker waits while the receiver stalls and never drops a word.

Top module: `ldw_walker`

## Requirements
- R1: The walk uses start_addr_i[23:0] only. If bit 23 of that masked value is 1, the walker issues no memory request and completes on the cycle after start with status 0 (end), final address equal to the masked value, and cost 0.
- R2: The header word gives the payload count in bits 31:24 and the next address in bits 23:0. Any 24-bit address is read at memory word address addr[20:2], so bits 22:21 have no effect on which word is read. The payload words follow the header at consecutive word addresses.
- R3: Payload words leave on out_data_o in increasing word-address order. Each word is held with out_valid_o high and unchanged until a cycle in which out_ready_i is high. No word is skipped or repeated.
- R4: A node with a payload count of 0 sends no word and moves straight on to its next address.
- R5: A walk whose next address has bit 23 set ends with status 0 and with that address on final_addr_o.
- R6: If a node's next address equals the current reference address, the walk ends with status 1 (loop) after that node's payload, and that next address is placed on final_addr_o.
- R7: The reference starts as the masked start address and the threshold starts at THRESH0. When node number k (counting from 0) completes without ending the walk and k equals the threshold, the reference becomes that node's next address and the threshold doubles.
- R8: When node number MAX_NODES-1 completes with a next address that neither loops nor has bit 23 set, the walk ends with status 2 (limit) and that next address on final_addr_o. A chain of exactly MAX_NODES nodes that ends normally reports status 0.
- R9: cost_o is cleared when a walk starts. It then grows by 10 for each node with count 0 and by 5 plus the count for each other node.
- R10: done_o is high for exactly one cycle per walk. busy_o is high from the cycle after an accepted start through the done cycle. Memory requests occur only while busy. status_o and final_addr_o keep their values until the next walk completes.
- R11: A start pulse while busy_o is high is ignored. The running walk and its results are unaffected.
- R12: After reset, busy_o, done_o, mem_req_o and out_valid_o are 0, and status_o, final_addr_o and cost_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| start_addr_i | input | 32 | Start address; bits 31:24 are ignored |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | Outcome: 0 end, 1 loop, 2 node limit |
| final_addr_o | output | 24 | Last address reached |
| cost_o | output | COST_W | Accumulated cost of the walk |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | MEM_BYTE_AW-2 | Memory word address |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a request |
| out_valid_o | output | 1 | Payload word valid |
| out_data_o | output | 32 | Payload word |
| out_ready_i | input | 1 | Receiver accepts the word |

## Verification
The bench builds the walker with THRESH0 = 4 and MAX_NODES = 20. With these values the reference reloads (at nodes 4, 8 and 16) and the node limit both occur within chains of a few dozen nodes. A three-node cycle entered from outside the cycle is caught only because the reference moves into the cycle at a reload. A linear chain of 25 empty nodes hits the limit, and a chain of exactly 20 nodes checks the boundary where the chain ends on the last permitted node.

// File: rtl/ldw_pkg.sv
package ldw_pkg;

  localparam int unsigned NODE_AW  = 24;
  localparam int unsigned TERM_BIT = 23;

  typedef enum logic [1:0] {
    WALK_END   = 2'd0,
    WALK_LOOP  = 2'd1,
    WALK_LIMIT = 2'd2
  } walk_status_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR_REQ,
    ST_HDR_WAIT,
    ST_PAY_REQ,
    ST_PAY_WAIT,
    ST_SEND,
    ST_DECIDE,
    ST_DONE
  } walk_state_e;

endpackage

// File: rtl/ldw_loop_guard.sv
module ldw_loop_guard #(
  parameter int unsigned THRESH0   = 32,
  parameter int unsigned MAX_NODES = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_i,
  input  logic [23:0] init_addr_i,
  input  logic        step_i,
  input  logic [23:0] next_addr_i,
  output logic        loop_hit_o,
  output logic        limit_hit_o
);

  localparam int unsigned CNT_W = $clog2(MAX_NODES + 1);
  localparam int unsigned THR_W = CNT_W + 1;

  logic [23:0]      ref_q, ref_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [THR_W-1:0] thr_q, thr_d;
  logic             upd_en;

  assign loop_hit_o  = (next_addr_i == ref_q);
  assign limit_hit_o = (idx_q == CNT_W'(MAX_NODES - 1));

  always_comb begin
    ref_d  = ref_q;
    idx_d  = idx_q;
    thr_d  = thr_q;
    upd_en = init_i | step_i;
    if (init_i) begin
      ref_d = init_addr_i;
      idx_d = '0;
      thr_d = THR_W'(THRESH0);
    end else if (step_i) begin
      idx_d = idx_q + CNT_W'(1);
      if ({1'b0, idx_q} == thr_q) begin
        ref_d = next_addr_i;
        thr_d = thr_q << 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      idx_q <= '0;
      thr_q <= '0;
    end else if (upd_en) begin
      ref_q <= ref_d;
      idx_q <= idx_d;
      thr_q <= thr_d;
    end
  end

endmodule

// File: rtl/ldw_cost_acc.sv
module ldw_cost_acc #(
  parameter int unsigned COST_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [7:0]        count_i,
  output logic [COST_W-1:0] cost_o
);

  localparam logic [COST_W-1:0] EMPTY_COST = COST_W'(10);
  localparam logic [COST_W-1:0] BASE_COST  = COST_W'(5);

  logic [COST_W-1:0] cost_q, cost_d, incr;
  logic              cost_en;

  always_comb begin
    incr    = (count_i == 8'd0) ? EMPTY_COST : (BASE_COST + COST_W'(count_i));
    cost_en = clr_i | add_i;
    cost_d  = clr_i ? '0 : (cost_q + incr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cost_q <= '0;
    else if (cost_en) cost_q <= cost_d;
  end

  assign cost_o = cost_q;

endmodule

// File: rtl/ldw_walker.sv
module ldw_walker
  import ldw_pkg::*;
#(
  parameter int unsigned MEM_BYTE_AW = 21,
  parameter int unsigned THRESH0     = 32,
  parameter int unsigned MAX_NODES   = 4096,
  parameter int unsigned COST_W      = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [31:0]            start_addr_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [1:0]             status_o,
  output logic [23:0]            final_addr_o,
  output logic [COST_W-1:0]      cost_o,
  output logic                   mem_req_o,
  output logic [MEM_BYTE_AW-3:0] mem_addr_o,
  input  logic [31:0]            mem_rdata_i,
  output logic                   out_valid_o,
  output logic [31:0]            out_data_o,
  input  logic                   out_ready_i
);

  localparam int unsigned WORD_AW = MEM_BYTE_AW - 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  walk_state_e        state_q, state_d;
  logic [23:0]        cur_q, cur_d;
  logic [23:0]        nxt_q, nxt_d;
  logic [WORD_AW-1:0] ptr_q, ptr_d;
  logic [7:0]         left_q, left_d;
  logic [31:0]        data_q;
  logic [1:0]         status_q, status_d;
  logic [23:0]        final_q, final_d;

  logic        walk_en, hdr_en, data_en, res_en;
  logic        g_init, g_step, g_loop, g_limit;
  logic        c_clr, c_add;
  logic [23:0] start_masked;

  assign start_masked = start_addr_i[23:0];

  ldw_loop_guard #(
    .THRESH0   (THRESH0),
    .MAX_NODES (MAX_NODES)
  ) u_guard (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .init_i      (g_init),
    .init_addr_i (start_masked),
    .step_i      (g_step),
    .next_addr_i (nxt_q),
    .loop_hit_o  (g_loop),
    .limit_hit_o (g_limit)
  );

  ldw_cost_acc #(
    .COST_W (COST_W)
  ) u_cost (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr_i   (c_clr),
    .add_i   (c_add),
    .count_i (mem_rdata_i[31:24]),
    .cost_o  (cost_o)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    cur_d    = cur_q;
    nxt_d    = nxt_q;
    ptr_d    = ptr_q;
    left_d   = left_q;
    status_d = status_q;
    final_d  = final_q;
    walk_en  = 1'b0;
    hdr_en   = 1'b0;
    data_en  = 1'b0;
    res_en   = 1'b0;
    g_init   = 1'b0;
    g_step   = 1'b0;
    c_clr    = 1'b0;
    c_add    = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          walk_en = 1'b1;
          g_init  = 1'b1;
          c_clr   = 1'b1;
          cur_d   = start_masked;
          if (start_masked[TERM_BIT]) begin
            res_en   = 1'b1;
            status_d = WALK_END;
            final_d  = start_masked;
            state_d  = ST_DONE;
          end else begin
            state_d = ST_HDR_REQ;
          end
        end
      end
      ST_HDR_REQ: state_d = ST_HDR_WAIT;
      ST_HDR_WAIT: begin
        hdr_en  = 1'b1;
        c_add   = 1'b1;
        nxt_d   = mem_rdata_i[23:0];
        left_d  = mem_rdata_i[31:24];
        ptr_d   = cur_q[MEM_BYTE_AW-1:2] + WORD_AW'(1);
        state_d = (mem_rdata_i[31:24] == 8'd0) ? ST_DECIDE : ST_PAY_REQ;
      end
      ST_PAY_REQ:  state_d = ST_PAY_WAIT;
      ST_PAY_WAIT: begin
        data_en = 1'b1;
        state_d = ST_SEND;
      end
      ST_SEND: begin
        if (out_ready_i) begin
          hdr_en  = 1'b1;
          left_d  = left_q - 8'd1;
          ptr_d   = ptr_q + WORD_AW'(1);
          state_d = (left_q == 8'd1) ? ST_DECIDE : ST_PAY_REQ;
        end
      end
      ST_DECIDE: begin
        if (g_loop) begin
          res_en   = 1'b1;
          status_d = WALK_LOOP;
          final_d  = nxt_q;
          state_d  = ST_DONE;
        end else if (nxt_q[TERM_BIT]) begin
          res_en   = 1'b1;
          status_d = WALK_END;
          final_d  = nxt_q;
          state_d  = ST_DONE;
        end else if (g_limit) begin
          res_en   = 1'b1;
          status_d = WALK_LIMIT;
          final_d  = nxt_q;
          state_d  = ST_DONE;
        end else begin
          g_step  = 1'b1;
          walk_en = 1'b1;
          cur_d   = nxt_q;
          state_d = ST_HDR_REQ;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_IDLE;
    else            state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   cur_q <= '0;
    else if (walk_en) cur_q <= cur_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      nxt_q  <= '0;
      ptr_q  <= '0;
      left_q <= '0;
    end else if (hdr_en) begin
      nxt_q  <= nxt_d;
      ptr_q  <= ptr_d;
      left_q <= left_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   data_q <= '0;
    else if (data_en) data_q <= mem_rdata_i;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      status_q <= '0;
      final_q  <= '0;
    end else if (res_en) begin
      status_q <= status_d;
      final_q  <= final_d;
    end
  end

  // outputs
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_DONE);
  assign status_o     = status_q;
  assign final_addr_o = final_q;
  assign mem_req_o    = (state_q == ST_HDR_REQ) || (state_q == ST_PAY_REQ);
  assign mem_addr_o   = (state_q == ST_HDR_REQ) ? cur_q[MEM_BYTE_AW-1:2] : ptr_q;
  assign out_valid_o  = (state_q == ST_SEND);
  assign out_data_o   = data_q;

endmodule

// File: rtl/ldw_walker_chk.sv
module ldw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy_o,
  input logic        done_o,
  input logic [1:0]  status_o,
  input logic [23:0] final_addr_o,
  input logic        mem_req_o,
  input logic        out_valid_o,
  input logic [31:0] out_data_o,
  input logic        out_ready_i
);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_fetch_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> busy_o);

  assert_word_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  assert_end_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o == 2'd0) |-> final_addr_o[23]);

  assert_status_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (status_o != 2'd3));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!out_valid_o && !mem_req_o));

endmodule

bind ldw_walker ldw_walker_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .status_o     (status_o),
  .final_addr_o (final_addr_o),
  .mem_req_o    (mem_req_o),
  .out_valid_o  (out_valid_o),
  .out_data_o   (out_data_o),
  .out_ready_i  (out_ready_i)
);

// File: tb/ldw_walker_tb.sv
`timescale 1ns/1ps
module ldw_walker_tb;

  localparam int unsigned T0   = 4;
  localparam int unsigned MAXN = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] start_addr_i = '0;
  logic        busy_o, done_o, mem_req_o, out_valid_o;
  logic [1:0]  status_o;
  logic [23:0] final_addr_o;
  logic [31:0] cost_o;
  logic [18:0] mem_addr_o;
  logic [31:0] mem_rdata_i = '0;
  logic [31:0] out_data_o;
  logic        out_ready_i = 1'b1;

  always #2.5 clk = ~clk;

  ldw_walker #(.MEM_BYTE_AW(21), .THRESH0(T0), .MAX_NODES(MAXN), .COST_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .busy_o(busy_o), .done_o(done_o), .status_o(status_o), .final_addr_o(final_addr_o),
    .cost_o(cost_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rdata_i(mem_rdata_i), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
    .out_ready_i(out_ready_i));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int mem_reqs = 0;
  int ready_mode = 0;
  logic [31:0] mem [int];
  logic [31:0] exp_q [$];
  logic [1:0]  exp_status;
  logic [23:0] exp_final;
  int          exp_cost;

  task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [23:0] a, input int off);
    int w;
    w = (int'(a & 24'h1FFFFF) >> 2) + off;
    w = w & 32'h7FFFF;
    if (mem.exists(w)) return mem[w];
    return 32'h0;
  endfunction

  task automatic put(input logic [23:0] a, input logic [31:0] d);
    mem[int'(a & 24'h1FFFFF) >> 2] = d;
  endtask

  // behavioural reference: walks the bench memory by the stated rules
  task automatic model(input logic [31:0] st);
    logic [23:0] a, nx, rf;
    logic [31:0] h;
    int thr, k, n;
    exp_q.delete();
    a = st[23:0]; rf = a; thr = T0; k = 0; exp_cost = 0;
    if (a[23]) begin
      exp_status = 2'd0; exp_final = a; return;
    end
    forever begin
      h = rd(a, 0);
      n = int'(h[31:24]);
      nx = h[23:0];
      exp_cost += (n == 0) ? 10 : 5 + n;
      for (int i = 1; i <= n; i++) exp_q.push_back(rd(a, i));
      if (nx == rf) begin exp_status = 2'd1; exp_final = nx; return; end
      if (nx[23])   begin exp_status = 2'd0; exp_final = nx; return; end
      if (k + 1 == int'(MAXN)) begin exp_status = 2'd2; exp_final = nx; return; end
      if (k == thr) begin rf = nx; thr = thr * 2; end
      k++;
      a = nx;
    end
  endtask

  // memory: data one cycle after the request
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req_o) begin
      mem_reqs <= mem_reqs + 1;
      mem_rdata_i <= mem.exists(int'(mem_addr_o)) ? mem[int'(mem_addr_o)] : 32'h0;
    end
  end

  // receiver: set ready, then compare the word that transfers at the next edge (R3)
  always @(negedge clk) begin
    logic r;
    case (ready_mode)
      1:       r = (cyc % 3) != 0;
      2:       r = (cyc % 7) > 3;
      default: r = 1'b1;
    endcase
    out_ready_i = r;
    if (rst_n && out_valid_o && r) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 extra word", out_data_o, 32'h0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(out_data_o == e, "R3 word order", out_data_o, e);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_walk(input logic [31:0] st, input string tag, input int mode, input bit poke);
    int n;
    logic [23:0] fin;
    model(st);
    ready_mode = mode;
    @(negedge clk);
    start_i = 1'b1; start_addr_i = st;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R10 busy after start", busy_o, 1);
    n = 0;
    while (!done_o && n < 5000) begin
      @(negedge clk);
      n++;
      if (poke && n == 2) begin start_i = 1'b1; start_addr_i = 32'h0080_0000; end
      if (poke && n == 3) start_i = 1'b0;
    end
    chk(done_o == 1'b1, {tag, " done seen"}, done_o, 1);
    chk(status_o == exp_status, {tag, " status"}, status_o, exp_status);
    chk(final_addr_o == exp_final, {tag, " final address"}, final_addr_o, exp_final);
    chk(cost_o == exp_cost, "R9 cost", cost_o, exp_cost);
    chk(exp_q.size() == 0, "R3 all words sent", exp_q.size(), 0);
    fin = final_addr_o;
    @(negedge clk);
    chk(done_o == 1'b0, "R10 done single cycle", done_o, 0);
    chk(busy_o == 1'b0, "R10 idle after done", busy_o, 0);
    chk(final_addr_o == fin, "R10 final held", final_addr_o, fin);
  endtask

  initial begin
    int rq;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(busy_o == 0 && done_o == 0 && mem_req_o == 0 && out_valid_o == 0, "R12 reset controls",
        {busy_o, done_o, mem_req_o, out_valid_o}, 0);
    chk(status_o == 0 && final_addr_o == 0 && cost_o == 0, "R12 reset results", final_addr_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: terminated start, no memory access
    rq = mem_reqs;
    run_walk(32'hFF80_0010, "R1", 0, 0);
    chk(mem_reqs == rq, "R1 no memory request", mem_reqs - rq, 0);
    chk(final_addr_o == 24'h800010, "R1 masked final", final_addr_o, 24'h800010);

    // R2/R4/R5 chain: aliased addresses, empty node, terminator
    put(24'h000100, {8'd3, 24'h200200});
    put(24'h000104, 32'hA000_0001); put(24'h000108, 32'hA000_0002); put(24'h00010C, 32'hA000_0003);
    put(24'h000200, {8'd0, 24'h400300});
    put(24'h000300, {8'd2, 24'h8ABCDE});
    put(24'h000304, 32'hB000_0001); put(24'h000308, 32'hB000_0002);
    run_walk(32'hAB00_0100, "R2 R4 R5", 0, 0);
    chk(cost_o == 25, "R4 R9 empty node cost", cost_o, 25);
    run_walk(32'hAB00_0100, "R3 stalls a", 1, 0);
    run_walk(32'h0000_0100, "R3 stalls b", 2, 0);

    // R11: start while busy
    run_walk(32'h0000_0100, "R11 start ignored", 2, 1);

    // R6: self loop
    put(24'h001000, {8'd1, 24'h001000});
    put(24'h001004, 32'hC0DE_0001);
    run_walk(32'h0000_1000, "R6 self loop", 0, 0);
    chk(status_o == 2'd1, "R6 loop code", status_o, 1);

    // R7: cycle not containing the start, caught after reference reload
    put(24'h002000, {8'd1, 24'h002100}); put(24'h002004, 32'hD000_0001);
    put(24'h002100, {8'd0, 24'h002200});
    put(24'h002200, {8'd2, 24'h002300}); put(24'h002204, 32'hD000_0002); put(24'h002208, 32'hD000_0003);
    put(24'h002300, {8'd0, 24'h002100});
    run_walk(32'h0000_2000, "R7 reload loop", 1, 0);
    chk(status_o == 2'd1 && final_addr_o == 24'h002200, "R7 loop at reloaded reference",
        final_addr_o, 24'h002200);

    // R8: node limit, and an exact-length chain that ends normally
    for (int i = 0; i < 25; i++)
      put(24'h004000 + 24'(i * 16), {8'd0, (i == 24) ? 24'h800000 : 24'h004000 + 24'((i + 1) * 16)});
    run_walk(32'h0000_4000, "R8 limit", 0, 0);
    chk(status_o == 2'd2, "R8 limit code", status_o, 2);
    run_walk(32'h0000_4050, "R8 exact length end", 0, 0);
    chk(status_o == 2'd0, "R8 twenty nodes end normally", status_o, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule